// File: doc/BRIEF.md
# Packed Pixel RAM Adapter

The adapter makes a byte-wide single-port RAM look like an array of small pixels. Each request carries a 20-bit pixel address, a read or write flag, a format bit and write data. The format bit picks one of two packing densities: four bits per pixel (two pixels in each byte) or two bits per pixel (four pixels in each byte). The format is chosen per request, so software can switch the density at run time.

A read returns the addressed pixel in the low bits of an 8-bit result, with the upper bits cleared. A write changes only the addressed pixel's bits. The other pixels in the same byte keep their values. To do this, every write is split into a RAM read followed by a RAM write of the merged byte. The byte address is cut to the RAM's own address width, so pixel addresses beyond the RAM alias back onto it.

Requests use a valid/ready handshake. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the adapter is idle, so an upstream source stalls by holding its request valid until ready returns. The response is a single-cycle pulse. It has no back-pressure: a consumer must take `rsp_rdata` in the cycle where `rsp_valid` is high.

Top module: `pix_ram_adapter`

## Requirements
- R1: Format bit 0 selects four bits per pixel. In this mode the RAM byte address is the pixel address shifted right by one. Pixel address bit 0 selects the byte's bits [3:0] when 0 and bits [7:4] when 1.
- R2: Format bit 1 selects two bits per pixel. In this mode the RAM byte address is the pixel address shifted right by two. The value n in pixel address bits [1:0] selects byte bits [2n+1:2n].
- R3: A write puts the low 4 bits (format 0) or the low 2 bits (format 1) of `req_wdata` into the selected field. Every other bit of the byte is left unchanged.
- R4: The RAM byte address keeps only its low RAM_AW bits. With the default RAM_AW of 10, byte address 0x402 reaches RAM byte 0x002.
- R5: When `rsp_valid` is high, `rsp_rdata` holds the selected field of the addressed byte in its low bits and zeros above. For a write, this field value is the one the byte had before the write.
- R6: A read makes one RAM read cycle, with `ram_en` high and `ram_we` low. A write makes that same read cycle and then, in the next cycle, one RAM write cycle with `ram_en` and `ram_we` both high.
- R7: `req_ready` is high only when the adapter is idle. `busy` is high from the cycle after acceptance through the response cycle. While the adapter is busy, no new request is taken.
- R8: `rsp_valid` is high for exactly one cycle: the second cycle after the accepting clock edge. The adapter is idle and ready again in the following cycle.
- R9: The format bit is sampled when a request is accepted. Changes on `req_fmt` while the request is in flight have no effect on it.
- R10: After reset the adapter is idle. `req_ready` is high, and `busy`, `rsp_valid` and `ram_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter can accept a request (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fmt | input | 1 | 0 = four bits per pixel, 1 = two bits per pixel |
| req_addr | input | 20 | Pixel address |
| req_wdata | input | 8 | Write data; only the low field bits are used |
| busy | output | 1 | A request is in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Zero-extended pixel field |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | RAM_AW | RAM byte address |
| ram_wdata | output | 8 | Merged byte to write |
| ram_rdata | input | 8 | RAM read data, valid one cycle after a read cycle |

## Verification
For every request, the bench drives its inputs on the falling edge. It then checks `busy`, `req_ready` and the RAM read strobe in the first cycle after the accepting edge. It checks `rsp_valid`, `rsp_rdata` and the write strobe in the second cycle, and idle in the third, always sampling on falling edges. Expected pixel values come from a hand-worked vector table. The table walks both formats, every field position, merges next to pixels that are already nonzero, and the aliasing of addresses beyond the RAM. Directed tests cover the reset state and a format bit that toggles while a request is in flight.

// File: rtl/pix_pkg.sv
package pix_pkg;
  localparam int PIX_AW = 20;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_FINISH = 2'd2
  } seq_state_t;

  typedef enum logic {
    FMT_4BPP = 1'b0,
    FMT_2BPP = 1'b1
  } pix_fmt_t;
endpackage

// File: rtl/pix_addr_map.sv
module pix_addr_map
  import pix_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic [PIX_AW-1:0] pix_addr,
  input  pix_fmt_t          fmt,
  output logic [RAM_AW-1:0] byte_addr,
  output logic [BYTE_W-1:0] field_mask,
  output logic [2:0]        field_shift
);
  localparam logic [BYTE_W-1:0] MASK4 = 8'h0F;
  localparam logic [BYTE_W-1:0] MASK2 = 8'h03;

  logic unused_hi;
  assign unused_hi = ^pix_addr;

  always_comb begin
    if (fmt == FMT_4BPP) begin
      byte_addr   = pix_addr[RAM_AW:1];
      field_shift = {pix_addr[0], 2'b00};
      field_mask  = MASK4 << field_shift;
    end else begin
      byte_addr   = pix_addr[RAM_AW+1:2];
      field_shift = {pix_addr[1:0], 1'b0};
      field_mask  = MASK2 << field_shift;
    end
  end

  initial begin
    assert (RAM_AW + 2 <= PIX_AW) else $error("RAM_AW too wide for pixel address");
  end
endmodule

// File: rtl/pix_field.sv
module pix_field
  import pix_pkg::*;
(
  input  logic [BYTE_W-1:0] old_byte,
  input  logic [BYTE_W-1:0] new_data,
  input  logic [BYTE_W-1:0] field_mask,
  input  logic [2:0]        field_shift,
  output logic [BYTE_W-1:0] merged,
  output logic [BYTE_W-1:0] extracted
);
  logic [BYTE_W-1:0] placed;

  assign placed    = new_data << field_shift;
  assign extracted = (old_byte & field_mask) >> field_shift;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    assign merged[b] = field_mask[b] ? placed[b] : old_byte[b];
  end
endmodule

// File: rtl/pix_seq.sv
module pix_seq
  import pix_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic in_read,
  output logic in_finish,
  output logic write_q
);
  seq_state_t state;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_read   = (state == ST_READ);
  assign in_finish = (state == ST_FINISH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      write_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_READ;
          write_q <= req_write;
        end
        ST_READ:   state <= ST_FINISH;
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  p_finish_after_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_read |=> in_finish);
  p_state_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, in_read, in_finish}) && (req_ready || in_read || in_finish));
endmodule

// File: rtl/pix_ram_adapter.sv
module pix_ram_adapter
  import pix_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_fmt,
  input  logic [19:0]       req_addr,
  input  logic [7:0]        req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [7:0]        rsp_rdata,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata
);
  logic              accept, in_read, in_finish, write_q;
  logic [PIX_AW-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  pix_fmt_t          fmt_q;
  logic [BYTE_W-1:0] field_mask, merged, extracted;
  logic [2:0]        field_shift;

  pix_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .in_read   (in_read),
    .in_finish (in_finish),
    .write_q   (write_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      fmt_q   <= FMT_4BPP;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      fmt_q   <= pix_fmt_t'(req_fmt);
    end
  end

  pix_addr_map #(.RAM_AW(RAM_AW)) u_map (
    .pix_addr    (addr_q),
    .fmt         (fmt_q),
    .byte_addr   (ram_addr),
    .field_mask  (field_mask),
    .field_shift (field_shift)
  );

  pix_field u_field (
    .old_byte    (ram_rdata),
    .new_data    (wdata_q),
    .field_mask  (field_mask),
    .field_shift (field_shift),
    .merged      (merged),
    .extracted   (extracted)
  );

  assign busy      = in_read || in_finish;
  assign ram_we    = in_finish && write_q;
  assign ram_en    = in_read || ram_we;
  assign ram_wdata = merged;
  assign rsp_valid = in_finish;
  assign rsp_rdata = in_finish ? extracted : '0;

  p_accept_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ram_en && !ram_we && busy));
  p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(ram_en && !ram_we));
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
  p_fmt_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fmt_q));
  p_keep_neighbours_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (((ram_wdata ^ ram_rdata) & ~field_mask) == 8'h00));
  p_zext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((fmt_q == FMT_2BPP) ? (rsp_rdata[7:2] == 6'd0) : (rsp_rdata[7:4] == 4'd0)));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_en);
endmodule

// File: tb/pix_ram_adapter_bench.sv
module pix_ram_adapter_bench;
  localparam int AW = 10;

  typedef struct packed {
    logic        wr;
    logic        fmt;
    logic [19:0] addr;
    logic [7:0]  wd;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 20'h00004, 8'hA5, 8'h00},
    '{1'b1, 1'b0, 20'h00005, 8'h3C, 8'h00},
    '{1'b0, 1'b0, 20'h00004, 8'h00, 8'h05},
    '{1'b0, 1'b0, 20'h00005, 8'h00, 8'h0C},
    '{1'b0, 1'b1, 20'h00008, 8'h00, 8'h01},
    '{1'b0, 1'b1, 20'h00009, 8'h00, 8'h01},
    '{1'b0, 1'b1, 20'h0000A, 8'h00, 8'h00},
    '{1'b0, 1'b1, 20'h0000B, 8'h00, 8'h03},
    '{1'b1, 1'b1, 20'h0000A, 8'hFE, 8'h00},
    '{1'b0, 1'b0, 20'h00005, 8'h00, 8'h0E},
    '{1'b0, 1'b0, 20'h00004, 8'h00, 8'h05},
    '{1'b1, 1'b1, 20'h00010, 8'h03, 8'h00},
    '{1'b1, 1'b1, 20'h00013, 8'h02, 8'h00},
    '{1'b0, 1'b0, 20'h00009, 8'h00, 8'h08},
    '{1'b0, 1'b0, 20'h00008, 8'h00, 8'h03},
    '{1'b0, 1'b0, 20'h00804, 8'h00, 8'h05},
    '{1'b0, 1'b1, 20'h0100B, 8'h00, 8'h03},
    '{1'b1, 1'b0, 20'hFFFFF, 8'h97, 8'h00},
    '{1'b0, 1'b1, 20'hFFFFF, 8'h00, 8'h01},
    '{1'b1, 1'b0, 20'h00004, 8'h07, 8'h05},
    '{1'b0, 1'b1, 20'h00008, 8'h00, 8'h03},
    '{1'b0, 1'b0, 20'h00005, 8'h00, 8'h0E}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_fmt = 1'b0;
  logic [19:0]   req_addr = '0;
  logic [7:0]    req_wdata = '0;
  logic          req_ready, busy, rsp_valid, ram_en, ram_we;
  logic [7:0]    rsp_rdata, ram_wdata, ram_rdata;
  logic [AW-1:0] ram_addr;
  logic [7:0]    mem [2**AW];
  int            errors = 0, checks = 0;

  always #5 clk = ~clk;

  initial begin
    for (int i = 0; i < 2**AW; i++) mem[i] = 8'h00;
    ram_rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        ram_rdata     <= mem[ram_addr];
    end
  end

  pix_ram_adapter #(.RAM_AW(AW)) u_pix_ram_adapter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_fmt(req_fmt), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic wr, input logic fmt, input logic [19:0] a,
                        input logic [7:0] wd, input logic [7:0] exp,
                        input bit flip_fmt, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_fmt = fmt; req_addr = a; req_wdata = wd;
    check({tag, " R7 ready while idle"}, {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_wdata = 8'h00;
    if (flip_fmt) req_fmt = ~fmt;
    check({tag, " R7 busy/ready in read cycle"}, {30'd0, busy, req_ready}, 32'd2);
    check({tag, " R6 read strobe"}, {30'd0, ram_en, ram_we}, 32'd2);
    check({tag, " R8 no early done"}, {31'd0, rsp_valid}, 32'd0);
    @(negedge clk);
    check({tag, " R8 done pulse"}, {31'd0, rsp_valid}, 32'd1);
    check({tag, " R5 R1 R2 R3 R4 field value"}, {24'd0, rsp_rdata}, {24'd0, exp});
    check({tag, " R6 write strobe"}, {30'd0, ram_en, ram_we}, {30'd0, wr, wr});
    @(negedge clk);
    check({tag, " R8 back to idle"}, {29'd0, rsp_valid, busy, req_ready}, 32'd1);
    req_fmt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset ready", {31'd0, req_ready}, 32'd1);
    check("R10 reset busy/done/ram_en", {29'd0, busy, rsp_valid, ram_en}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i].wr, VECS[i].fmt, VECS[i].addr, VECS[i].wd, VECS[i].exp,
             1'b0, $sformatf("vec%0d", i));
    end

    // R9: format toggled after acceptance must not affect the request
    run_op(1'b0, 1'b0, 20'h00005, 8'h00, 8'h0E, 1'b1, "R9 fmt0 held");
    run_op(1'b0, 1'b1, 20'h00009, 8'h00, 8'h01, 1'b1, "R9 fmt1 held");
    // R4: alias of byte 0x3FF reached from a pixel address below the top
    run_op(1'b0, 1'b0, 20'h007FF, 8'h00, 8'h07, 1'b0, "R4 alias 0x3FF");
    // R3: neighbours of byte 2 after all writes (0xE7)
    run_op(1'b0, 1'b1, 20'h0000A, 8'h00, 8'h02, 1'b0, "R3 neighbour kept");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule